// File: doc/BRIEF.md
# DCC Packet Framer with Inline XOR Check

The framer sits behind a bit-timing front end that has already classified each line bit as a one or a zero. It hunts for a preamble: more than a set number of consecutive ones. Once it finds one, it asks the front end to enter half-bit sync mode and waits for the zero that acts as the start bit. It then shifts in data bytes, most significant bit first. After each byte it reads one more bit. A zero in that position means another byte follows, and a one ends the packet.

A running XOR of all received bytes is kept while the packet arrives. At the end bit the packet is handed over only if that XOR is zero. A packet that fails the check is dropped and counted. A released packet is copied into a holding buffer and stays stable there until the consumer acknowledges it. The holding buffer carries the bytes, the byte count and the number of preamble ones seen before the start bit. If a newer valid packet arrives before the acknowledgement, it replaces the held one and an overrun flag is raised.

Consecutive-ones detection runs in every state except the start-bit search. A preamble found at any other time restarts the start-bit search and abandons any packet in progress. Decoding of addresses and commands is left to the consumer.

Top module: `dcc_pkt_framer`

## Requirements
- R1: After reset, `half_sync_o`, `pkt_rdy_o`, `pkt_avail_o` and `pkt_ovr_o` are 0, `err_cnt_o` is 0, and the block is waiting for a preamble.
- R2: While waiting for a preamble, the (PRE_MIN+1)th consecutive one raises `half_sync_o` in the cycle after that bit is taken. A zero bit clears the run of ones, so PRE_MIN ones after a zero do not raise it.
- R3: While `half_sync_o` is high, further one bits keep it high. A zero bit is the start bit: it drops `half_sync_o` and begins byte reception.
- R4: Data bits are assembled most significant bit first, 8 per byte. Received byte i appears on `pkt_data_o[8*i+7:8*i]`, and `pkt_len_o` gives the byte count.
- R5: The bit after each byte is a separator. A 0 starts another byte, and a 1 ends the packet.
- R6: At the end bit, a packet whose bytes XOR to zero is released. `pkt_rdy_o` pulses for one cycle, and `pkt_avail_o` is set in the cycle after the end bit.
- R7: A packet whose bytes do not XOR to zero is not released. `err_cnt_o` rises by one (saturating), and the held output is left unchanged.
- R8: A 0 separator after MAX_LEN bytes aborts the packet and returns the block to preamble search. The following bits release nothing.
- R9: `pkt_pre_o` gives the number of consecutive ones received just before the start bit, saturating at 2^PRE_W-1.
- R10: A held packet and `pkt_avail_o` stay unchanged until `pkt_ack_i` is pulsed. The acknowledgement clears `pkt_avail_o` and `pkt_ovr_o`.
- R11: A valid packet released while `pkt_avail_o` is high, without an acknowledgement in the same cycle, replaces the held packet and sets `pkt_ovr_o`.
- R12: Byte positions at or above `pkt_len_o` in `pkt_data_o` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_vld_i | input | 1 | One classified bit is present this cycle |
| bit_val_i | input | 1 | Value of the classified bit |
| pkt_ack_i | input | 1 | Consumer has taken the held packet |
| half_sync_o | output | 1 | Request to the front end for half-bit sync (start-bit search) |
| pkt_rdy_o | output | 1 | One-cycle strobe: new packet released |
| pkt_avail_o | output | 1 | Held packet not yet acknowledged |
| pkt_ovr_o | output | 1 | Held packet replaced before acknowledgement |
| pkt_data_o | output | 8*MAX_LEN | Held bytes, byte i at bits 8*i+7:8*i |
| pkt_len_o | output | $clog2(MAX_LEN+1) | Held byte count |
| pkt_pre_o | output | PRE_W | Preamble ones counted before the start bit |
| err_cnt_o | output | ERR_W | Saturating count of XOR failures |

## Verification
Several properties are checked on every cycle by the assertions. A zero bit always clears the run of ones. A start bit always enters byte reception. A separator zero on a full buffer always returns the block to preamble search. A release strobe only ever follows an end bit, and the error count only moves on an end bit. The held packet never changes without a release or an acknowledgement, and the byte count never exceeds its limit. Only the bench's scenarios can show that whole bit streams give the right bytes, the right byte order and the right preamble count. The same holds for how the XOR outcome decides between release and error, and for the overrun and acknowledgement sequences across several packets.

// File: rtl/dcc_framer_pkg.sv
package dcc_framer_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_PRE   = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_END   = 2'd3
  } fr_state_e;
endpackage

// File: rtl/dcc_run_cnt.sv
module dcc_run_cnt #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned THR   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_val_i,
  input  logic             arm_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(THR);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_vld_i) begin
      if (!bit_val_i)            cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = arm_i && bit_vld_i && bit_val_i && (cnt_q >= CNT_THR);

  // R2
  ones_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !bit_val_i) |=> (cnt_q == '0));
endmodule

// File: rtl/dcc_byte_asm.sv
module dcc_byte_asm
  import dcc_framer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      sh_q  <= '0;
    end else if (shift_i) begin
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      sh_q  <= {sh_q[BYTE_W-3:0], bit_i};
    end
  end

  // MSB first: earliest bit ends in the top position
  assign byte_o = {sh_q, bit_i};
  assign done_o = shift_i && (idx_q == IDX_LAST);

  // R4
  byte_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> (idx_q == '0));
endmodule

// File: rtl/dcc_pkt_store.sv
module dcc_pkt_store
  import dcc_framer_pkg::*;
#(
  parameter int unsigned MAX_LEN = 6,
  parameter int unsigned PRE_W   = 5,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned DATA_W = MAX_LEN * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rel_i,
  input  logic              ack_i,
  output logic [BYTE_W-1:0] xor_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic              rdy_o,
  output logic              avail_o,
  output logic              ovr_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic [BYTE_W-1:0] buf_q [MAX_LEN];
  logic [LEN_W-1:0]  len_q, out_len_q;
  logic [BYTE_W-1:0] xor_q;
  logic [PRE_W-1:0]  pre_q, out_pre_q;
  logic [DATA_W-1:0] out_q;
  logic              rdy_q, avail_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      xor_q <= '0;
      pre_q <= '0;
    end else if (clr_i) begin
      len_q <= '0;
      xor_q <= '0;
      pre_q <= pre_i;
    end else if (wr_i && !full_o) begin
      len_q <= len_q + 1'b1;
      xor_q <= xor_q ^ byte_i;
    end
  end

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   buf_q[i] <= '0;
      else if (wr_i && !clr_i && len_q == LEN_W'(i)) buf_q[i] <= byte_i;
    end

    // unused slots are zeroed on release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    out_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (rel_i) out_q[i*BYTE_W +: BYTE_W] <= (LEN_W'(i) < len_q) ? buf_q[i] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_len_q <= '0;
      out_pre_q <= '0;
      rdy_q     <= 1'b0;
      avail_q   <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      rdy_q <= rel_i;
      if (rel_i) begin
        out_len_q <= len_q;
        out_pre_q <= pre_q;
      end
      if (rel_i)      avail_q <= 1'b1;
      else if (ack_i) avail_q <= 1'b0;
      if (rel_i && avail_q && !ack_i) ovr_q <= 1'b1;
      else if (ack_i)                 ovr_q <= 1'b0;
    end
  end

  assign xor_o   = xor_q;
  assign full_o  = (len_q == LEN_MAX);
  assign data_o  = out_q;
  assign len_o   = out_len_q;
  assign pre_o   = out_pre_q;
  assign rdy_o   = rdy_q;
  assign avail_o = avail_q;
  assign ovr_o   = ovr_q;

  // R8
  len_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_MAX);

  // R6
  rdy_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |-> avail_q);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_q && !rel_i && !ack_i) |=> ($stable(out_q) && $stable(out_len_q) && avail_q));

  // R10
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !rel_i) |=> (!avail_q && !ovr_q));
endmodule

// File: rtl/dcc_pkt_framer.sv
module dcc_pkt_framer
  import dcc_framer_pkg::*;
#(
  parameter int unsigned MAX_LEN = 6,
  parameter int unsigned PRE_W   = 5,
  parameter int unsigned PRE_MIN = 10,
  parameter int unsigned ERR_W   = 8,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned DATA_W = MAX_LEN * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_val_i,
  input  logic              pkt_ack_i,
  output logic              half_sync_o,
  output logic              pkt_rdy_o,
  output logic              pkt_avail_o,
  output logic              pkt_ovr_o,
  output logic [DATA_W-1:0] pkt_data_o,
  output logic [LEN_W-1:0]  pkt_len_o,
  output logic [PRE_W-1:0]  pkt_pre_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  fr_state_e         state_q, state_d;
  logic              clr, shift, rel, bad;
  logic              pre_hit, byte_done, full;
  logic [PRE_W-1:0]  ones_cnt;
  logic [BYTE_W-1:0] byte_val, xor_val;
  logic [ERR_W-1:0]  err_q;

  dcc_run_cnt #(.CNT_W(PRE_W), .THR(PRE_MIN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld_i),
    .bit_val_i (bit_val_i),
    .arm_i     (state_q != ST_START),
    .cnt_o     (ones_cnt),
    .hit_o     (pre_hit)
  );

  dcc_byte_asm u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .shift_i (shift),
    .bit_i   (bit_val_i),
    .byte_o  (byte_val),
    .done_o  (byte_done)
  );

  dcc_pkt_store #(.MAX_LEN(MAX_LEN), .PRE_W(PRE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .pre_i   (ones_cnt),
    .wr_i    (byte_done),
    .byte_i  (byte_val),
    .rel_i   (rel),
    .ack_i   (pkt_ack_i),
    .xor_o   (xor_val),
    .full_o  (full),
    .data_o  (pkt_data_o),
    .len_o   (pkt_len_o),
    .pre_o   (pkt_pre_o),
    .rdy_o   (pkt_rdy_o),
    .avail_o (pkt_avail_o),
    .ovr_o   (pkt_ovr_o)
  );

  always_comb begin
    state_d = state_q;
    clr     = 1'b0;
    shift   = 1'b0;
    rel     = 1'b0;
    bad     = 1'b0;
    case (state_q)
      ST_START: if (bit_vld_i && !bit_val_i) begin
        state_d = ST_DATA;
        clr     = 1'b1;
      end
      ST_DATA: if (bit_vld_i) begin
        shift = 1'b1;
        if (byte_done) state_d = ST_END;
      end
      ST_END: if (bit_vld_i) begin
        if (!bit_val_i) begin
          state_d = full ? ST_PRE : ST_DATA;
        end else begin
          state_d = ST_PRE;
          rel     = (xor_val == '0);
          bad     = (xor_val != '0);
        end
      end
      default: ;
    endcase
    // a preamble seen outside start search overrides everything
    if (pre_hit) begin
      state_d = ST_START;
      rel     = 1'b0;
      bad     = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PRE;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      if (bad && err_q != {ERR_W{1'b1}}) err_q <= err_q + 1'b1;
    end
  end

  assign half_sync_o = (state_q == ST_START);
  assign err_cnt_o   = err_q;

  // R3
  start_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && bit_vld_i && !bit_val_i) |=> (state_q == ST_DATA));

  // R8
  full_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_END && bit_vld_i && !bit_val_i && full) |=> (state_q == ST_PRE));

  // R6
  rel_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rdy_o |-> ($past(state_q) == ST_END && $past(bit_vld_i) && $past(bit_val_i)));

  // R7
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != $past(err_q)) |-> ($past(state_q) == ST_END && $past(bit_vld_i) && $past(bit_val_i) && !pkt_rdy_o));
endmodule

// File: tb/dcc_pkt_framer_tb.sv
module dcc_pkt_framer_tb_top;
  localparam int MAX_LEN = 6;
  localparam int PRE_W   = 5;
  localparam int DW      = 8 * MAX_LEN;
  localparam int LW      = $clog2(MAX_LEN + 1);

  typedef struct packed {
    logic [7:0]    npre;
    logic [3:0]    n;
    logic [DW-1:0] d;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{8'd14, 4'd3, 48'h00_00_00_3C_3F_03},
    '{8'd12, 4'd2, 48'h00_00_00_00_A5_A5},
    '{8'd11, 4'd3, 48'h00_00_00_04_02_01},
    '{8'd40, 4'd6, 48'hF0_0F_88_44_22_11},
    '{8'd20, 4'd1, 48'h00_00_00_00_00_00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_val = 1'b0, ack = 1'b0;
  logic half_sync, rdy, avail, ovr;
  logic [DW-1:0] data;
  logic [LW-1:0] len;
  logic [PRE_W-1:0] pre;
  logic [7:0] err;

  int total = 0, bad = 0, exp_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dcc_pkt_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(bit_vld), .bit_val_i(bit_val),
    .pkt_ack_i(ack), .half_sync_o(half_sync), .pkt_rdy_o(rdy),
    .pkt_avail_o(avail), .pkt_ovr_o(ovr), .pkt_data_o(data),
    .pkt_len_o(len), .pkt_pre_o(pre), .err_cnt_o(err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_val = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_ones(input int k);
    for (int i = 0; i < k; i++) send_bit(1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // leading zero clears any run of ones, then preamble, start, bytes, separators
  task automatic send_pkt(input int npre, input logic [DW-1:0] d, input int n);
    send_bit(1'b0);
    send_ones(npre);
    send_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      send_byte(d[8*i +: 8]);
      send_bit(i == n - 1);
    end
  endtask

  function automatic logic [DW-1:0] mask_bytes(input logic [DW-1:0] d, input int n);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < MAX_LEN; i++) if (i < n) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic logic [7:0] xor_bytes(input logic [DW-1:0] d, input int n);
    logic [7:0] x = '0;
    for (int i = 0; i < n; i++) x ^= d[8*i +: 8];
    return x;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 half_sync", half_sync, 0);
    check("R1 rdy", rdy, 0);
    check("R1 avail", avail, 0);
    check("R1 ovr", ovr, 0);
    check("R1 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 a zero breaks the run; 10 ones not enough, 11th triggers
    send_bit(1'b0);
    send_ones(5);
    send_bit(1'b0);
    send_ones(10);
    check("R2 ten ones", half_sync, 0);
    send_bit(1'b1);
    check("R2 eleventh one", half_sync, 1);
    // R3 ones keep sync request, zero is start bit
    send_ones(3);
    check("R3 ones hold", half_sync, 1);
    send_bit(1'b0);
    check("R3 start bit", half_sync, 0);
    send_byte(8'h00);
    send_bit(1'b1);
    check("R6 rdy single", rdy, 1);
    check("R9 pre count", pre, 14);
    check("R4 len single", len, 1);
    pulse_ack();

    // table-driven packets
    for (int v = 0; v < NVEC; v++) begin
      automatic int np = int'(VECS[v].npre);
      automatic int n  = int'(VECS[v].n);
      automatic bit ok = (xor_bytes(VECS[v].d, n) == 8'h00);
      send_pkt(np, VECS[v].d, n);
      check("R6 rdy per xor", rdy, ok);
      if (ok) begin
        check("R4 data", data, mask_bytes(VECS[v].d, n));
        check("R5 len", len, n);
        check("R9 pre", pre, (np > 31) ? 31 : np);
        check("R6 avail", avail, 1);
        pulse_ack();
        check("R10 ack clears", avail, 0);
      end else begin
        exp_err++;
        check("R7 err count", err, exp_err);
        check("R7 avail", avail, 0);
      end
    end

    // R12: last vector (1 byte) followed a 6-byte one; upper bytes must be zero
    check("R12 upper zero", data[DW-1:8], 0);

    // R10 held packet survives a failing packet
    send_pkt(12, 48'h0000_0000_5555, 2);
    check("R10 avail A", avail, 1);
    send_pkt(12, 48'h0000_0000_0301, 2);
    exp_err++;
    check("R7 err held", err, exp_err);
    check("R10 data held", data, 48'h5555);
    check("R10 avail held", avail, 1);
    // R11 overrun
    send_pkt(13, 48'h0000_0000_7777, 2);
    check("R11 rdy", rdy, 1);
    check("R11 ovr", ovr, 1);
    check("R11 data new", data, 48'h7777);
    pulse_ack();
    check("R10 ovr cleared", ovr, 0);
    check("R10 avail cleared", avail, 0);

    // R8 separator zero after max bytes aborts
    send_bit(1'b0);
    send_ones(12);
    send_bit(1'b0);
    for (int i = 0; i < MAX_LEN; i++) begin
      send_byte(8'h00);
      send_bit(1'b0);
    end
    send_bit(1'b1);
    check("R8 no release", rdy, 0);
    check("R8 no sync", half_sync, 0);
    check("R8 avail", avail, 0);
    check("R8 err", err, exp_err);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule